// File: doc/BRIEF.md
# Machine-Cycle Bus Timing Sequencer

This block divides a fast input clock into machine cycles. Each machine cycle has six states, and each state has two phases, so one machine cycle is twelve input clocks. From that timing the block drives an external program-memory bus. A two-pin pair carries the address:

- The low port is multiplexed. It drives the low byte of a fetch address while the address latch enable (`ale`) pulses, then floats so the memory can return the code byte.
- The high port carries the high address byte.

Every machine cycle holds two fetch slots. Slot A runs from S1 to S3 and slot B runs from S4 to S6. A fetch is internal when the access strap allows on-chip code and the address lies below a threshold. An internal fetch takes its byte from an on-chip code-memory port and leaves `psen_n` and both ports idle. Every other fetch goes out on the bus. `ale` keeps pulsing in both cases, so it can serve as a clock output.

The execution side presents the fetch address on `pc_in`. It gets each code byte back as a one-tick `code_valid` pulse. It can discard the slot-B byte by holding `keep_second` low. A data-memory move is requested with `dm_req`, which is sampled in S4P1. Slot B of that machine cycle then becomes the data address phase. The following machine cycle is a transfer cycle: it has no program fetch, it skips its first `ale` pulse, and it drives a single read or write strobe.

Top module: `mcb_bus_seq`

Encodings used throughout: `state_idx` 0..5 means S1..S6, and `phase2` 0/1 means P1/P2. Tick n (0..11) is state n/2, phase n%2. The FSMs are:
- **Tick ring:** T_S1P1 through T_S6P2, with transitions advance (to the next tick) and wrap (T_S6P2 to T_S1P1).
- **Cycle mode:** M_FETCH, M_SETUP and M_XFER, with transitions request (M_FETCH to M_SETUP at the end of S4P1 when `dm_req` is set), arm (M_SETUP to M_XFER at the end of S6P2) and release (M_XFER to M_FETCH at the end of S6P2).

## Requirements
- R1: After reset the block sits in S1P1 (`state_idx`=0, `phase2`=0). It advances one tick per clock through all twelve ticks and wraps from S6P2 to S1P1.
- R2: `ale` is high in S1P2, S2P1, S4P2 and S5P1 of every machine cycle, for internal and external fetches alike. The one exception is a transfer cycle, where `ale` stays low in S1P2 and S2P1.
- R3: For an external fetch, `psen_n` is low in S3P1–S3P2 (slot A) or S6P1–S6P2 (slot B). The low port drives the address low byte (`lo_oe`=1) only in that slot's two `ale` ticks and floats afterwards. The high port drives the address high byte from S1P2 to S3P2 (slot A) or from S4P2 to S6P2 (slot B).
- R4: The fetch address is taken from `pc_in` at the end of S1P1 (slot A) and at the end of S4P1 (slot B). `rom_addr` shows the captured address.
- R5: A fetch is internal when `strap_int`=1 and the address is below 0x1000. An internal fetch keeps `psen_n` high and both ports undriven, and its byte comes from `rom_data`. With `strap_int`=0, or an address of 0x1000 or above, the fetch is external and its byte comes from `lo_in`.
- R6: The code byte is captured at the end of S3P2 (slot A) or S6P2 (slot B). `code_valid` is high for exactly one tick, in S4P1 or the next S1P1 respectively.
- R7: If `keep_second` is 0 at the end of S6P2, the slot-B byte is discarded: no `code_valid` appears in the next S1P1, and `code_byte` keeps its previous value.
- R8: When `dm_req` is sampled at the end of S4P1 in a fetch cycle, slot B carries no fetch. Instead:
  - `ale` latches `dm_addr`'s low byte, which the low port drives in S4P2–S5P1.
  - The high port drives `dm_addr[15:8]` (when `dm_wide`=1) or `hi_latch` (when `dm_wide`=0) from S4P2 through S3P2 of the next cycle.
  - `psen_n` stays high.
- R9: In the transfer cycle no program fetch occurs and `psen_n` stays high. `rd_n` (when `dm_write`=0) or `wr_n` (when `dm_write`=1) is low from S1P2 to S3P2. The second `ale` pulse still occurs.
- R10: For a write, the low port drives `dm_wdata` for the whole strobe window. For a read, the low port floats, the byte on `lo_in` is captured at the end of S3P2, and `data_valid` pulses in S4P1 of the transfer cycle.
- R11: `dm_active` is high from S4P2 of the request cycle through S6P2 of the transfer cycle. A `dm_req` seen while a move is under way is ignored, and fetching resumes in the next machine cycle.
- R12: During reset all strobes are inactive (`ale`=0, `psen_n`=`rd_n`=`wr_n`=1), both ports float with zero data, and `code_valid`, `data_valid` and `dm_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one tick per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_int | input | 1 | Access strap: 1 lets low addresses fetch from on-chip code |
| pc_in | input | 16 | Fetch address from the execution side |
| keep_second | input | 1 | 0 discards the slot-B code byte |
| rom_data | input | 8 | On-chip code byte at `rom_addr` |
| dm_req | input | 1 | Request a data-memory move |
| dm_write | input | 1 | 1 = write, 0 = read |
| dm_wide | input | 1 | 1 = 16-bit address, 0 = 8-bit address plus high-port latch |
| dm_addr | input | 16 | Data-memory address |
| dm_wdata | input | 8 | Write data |
| hi_latch | input | 8 | High-port latch contents used for 8-bit moves |
| lo_in | input | 8 | Value read from the low port pins |
| state_idx | output | 3 | Current state, 0..5 = S1..S6 |
| phase2 | output | 1 | 1 in phase 2 |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low port drive value |
| lo_oe | output | 1 | Low port drive enable |
| hi_out | output | 8 | High port drive value |
| hi_oe | output | 1 | High port drive enable |
| rom_addr | output | 16 | Captured fetch address |
| code_valid | output | 1 | One-tick code byte strobe |
| code_byte | output | 8 | Last captured code byte |
| data_valid | output | 1 | One-tick read data strobe |
| data_byte | output | 8 | Last read data byte |
| dm_active | output | 1 | A data move is in progress |

## Verification
Strobes, port enables and port values are decoded from the current tick, so they belong to the same tick as the state they describe. The captured values take longer:
- A fetch address applied at an S1P1 or S4P1 edge shows on `rom_addr` from the next tick.
- A code or read byte present at the end of S3P2 or S6P2 is reported one tick later, in S4P1 or S1P1.
- A `dm_req` sampled at S4P1 changes the bus from S4P2 of the same machine cycle.

The bench steps a behavioural tick model at every rising edge, using the very inputs the design sampled there. It then compares every output at the following falling edge, which keeps each expected value aligned with the register that produces it.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

    // Twelve oscillator ticks per machine cycle: state Sx, phase Py.
    typedef enum logic [3:0] {
        T_S1P1 = 4'd0,
        T_S1P2 = 4'd1,
        T_S2P1 = 4'd2,
        T_S2P2 = 4'd3,
        T_S3P1 = 4'd4,
        T_S3P2 = 4'd5,
        T_S4P1 = 4'd6,
        T_S4P2 = 4'd7,
        T_S5P1 = 4'd8,
        T_S5P2 = 4'd9,
        T_S6P1 = 4'd10,
        T_S6P2 = 4'd11
    } tick_e;

    // Kind of machine cycle being run.
    typedef enum logic [1:0] {
        M_FETCH = 2'd0,  // two program fetch slots
        M_SETUP = 2'd1,  // slot B carries the data address
        M_XFER  = 2'd2   // data strobe cycle, no program fetch
    } mode_e;

endpackage

// File: rtl/mcb_tick_ring.sv
module mcb_tick_ring
    import mcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    output tick_e      tick,
    output logic [2:0] state_idx,
    output logic       phase2
);

    tick_e tick_n;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= T_S1P1;
        end else begin
            tick <= tick_n;
        end
    end

    // Next tick and decoded outputs.
    always_comb begin
        unique case (tick)
            T_S6P2:  tick_n = T_S1P1;                 // wrap
            default: tick_n = tick_e'(tick + 4'd1);   // advance
        endcase
        state_idx = tick[3:1];
        phase2    = tick[0];
    end

endmodule

// File: rtl/mcb_mode_fsm.sv
module mcb_mode_fsm
    import mcb_pkg::*;
#(
    parameter int ADW = 16,
    parameter int DW  = 8,
    localparam int HW = ADW - DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  tick_e          tick,
    input  logic           dm_req,
    input  logic           dm_write,
    input  logic           dm_wide,
    input  logic [ADW-1:0] dm_addr,
    input  logic [DW-1:0]  dm_wdata,
    input  logic [HW-1:0]  hi_latch,
    output mode_e          mode,
    output logic           r_wr,
    output logic [DW-1:0]  r_alo,
    output logic [HW-1:0]  r_hi,
    output logic [DW-1:0]  r_wdata
);

    mode_e mode_n;
    logic  accept;

    assign accept = (mode == M_FETCH) && (tick == T_S4P1) && dm_req;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= M_FETCH;
        end else begin
            mode <= mode_n;
        end
    end

    // Transitions: request, arm, release.
    always_comb begin
        mode_n = mode;
        unique case (mode)
            M_FETCH: if (accept)           mode_n = M_SETUP;
            M_SETUP: if (tick == T_S6P2)   mode_n = M_XFER;
            M_XFER:  if (tick == T_S6P2)   mode_n = M_FETCH;
            default:                       mode_n = M_FETCH;
        endcase
    end

    // Request fields are held for the whole move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_wr    <= 1'b0;
            r_alo   <= '0;
            r_hi    <= '0;
            r_wdata <= '0;
        end else if (accept) begin
            r_wr    <= dm_write;
            r_alo   <= dm_addr[DW-1:0];
            r_hi    <= dm_wide ? dm_addr[ADW-1:DW] : hi_latch;
            r_wdata <= dm_wdata;
        end
    end

endmodule

// File: rtl/mcb_fetch_capture.sv
module mcb_fetch_capture
    import mcb_pkg::*;
#(
    parameter int          ADW       = 16,
    parameter int          DW        = 8,
    parameter int unsigned INT_LIMIT = 32'h1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  tick_e          tick,
    input  mode_e          mode,
    input  logic           strap_int,
    input  logic [ADW-1:0] pc_in,
    input  logic           keep_second,
    input  logic [DW-1:0]  rom_data,
    input  logic [DW-1:0]  lo_in,
    input  logic           r_wr,
    output logic [ADW-1:0] fa,
    output logic           fint,
    output logic           code_valid,
    output logic [DW-1:0]  code_byte,
    output logic           data_valid,
    output logic [DW-1:0]  data_byte
);

    localparam logic [ADW-1:0] LIMIT_V = ADW'(INT_LIMIT);

    logic take_addr;
    logic take_code;
    logic take_data;

    assign take_addr = (tick == T_S1P1) || (tick == T_S4P1);
    assign take_code = (mode == M_FETCH) &&
                       ((tick == T_S3P2) || ((tick == T_S6P2) && keep_second));
    assign take_data = (mode == M_XFER) && !r_wr && (tick == T_S3P2);

    // Fetch address and internal/external decision per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fa   <= '0;
            fint <= 1'b0;
        end else if (take_addr) begin
            fa   <= pc_in;
            fint <= strap_int && (pc_in < LIMIT_V);
        end
    end

    // Returned bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_valid <= 1'b0;
            code_byte  <= '0;
            data_valid <= 1'b0;
            data_byte  <= '0;
        end else begin
            code_valid <= take_code;
            data_valid <= take_data;
            if (take_code) begin
                code_byte <= fint ? rom_data : lo_in;
            end
            if (take_data) begin
                data_byte <= lo_in;
            end
        end
    end

endmodule

// File: rtl/mcb_strobe_gen.sv
module mcb_strobe_gen
    import mcb_pkg::*;
#(
    parameter int ADW = 16,
    parameter int DW  = 8,
    localparam int HW = ADW - DW
) (
    input  tick_e          tick,
    input  mode_e          mode,
    input  logic [ADW-1:0] fa,
    input  logic           fint,
    input  logic           r_wr,
    input  logic [DW-1:0]  r_alo,
    input  logic [HW-1:0]  r_hi,
    input  logic [DW-1:0]  r_wdata,
    output logic           ale,
    output logic           psen_n,
    output logic           rd_n,
    output logic           wr_n,
    output logic [DW-1:0]  lo_out,
    output logic           lo_oe,
    output logic [HW-1:0]  hi_out,
    output logic           hi_oe
);

    logic ale_a, ale_b, rd_a, rd_b, win_a, win_b, win_x;

    // Tick windows.
    always_comb begin
        ale_a = tick inside {T_S1P2, T_S2P1};
        ale_b = tick inside {T_S4P2, T_S5P1};
        rd_a  = tick inside {T_S3P1, T_S3P2};
        rd_b  = tick inside {T_S6P1, T_S6P2};
        win_a = tick inside {T_S1P2, T_S2P1, T_S2P2, T_S3P1, T_S3P2};
        win_b = tick inside {T_S4P2, T_S5P1, T_S5P2, T_S6P1, T_S6P2};
        win_x = win_a || (tick == T_S1P1);
    end

    // Output decode per cycle mode.
    always_comb begin
        ale    = ale_b;
        psen_n = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        lo_out = '0;
        lo_oe  = 1'b0;
        hi_out = '0;
        hi_oe  = 1'b0;
        unique case (mode)
            M_FETCH: begin
                ale = ale_a || ale_b;
                if (!fint) begin
                    psen_n = !(rd_a || rd_b);
                    if (ale_a || ale_b) begin
                        lo_oe  = 1'b1;
                        lo_out = fa[DW-1:0];
                    end
                    if (win_a || win_b) begin
                        hi_oe  = 1'b1;
                        hi_out = fa[ADW-1:DW];
                    end
                end
            end
            M_SETUP: begin
                ale = ale_a || ale_b;
                if (ale_b) begin
                    lo_oe  = 1'b1;
                    lo_out = r_alo;
                end
                if (win_b) begin
                    hi_oe  = 1'b1;
                    hi_out = r_hi;
                end
            end
            M_XFER: begin
                if (win_a) begin
                    rd_n = r_wr;
                    wr_n = !r_wr;
                    if (r_wr) begin
                        lo_oe  = 1'b1;
                        lo_out = r_wdata;
                    end
                end
                if (win_x) begin
                    hi_oe  = 1'b1;
                    hi_out = r_hi;
                end
            end
            default: begin
                ale = ale_b;
            end
        endcase
    end

endmodule

// File: rtl/mcb_bus_seq.sv
module mcb_bus_seq
    import mcb_pkg::*;
#(
    parameter int          ADW       = 16,
    parameter int          DW        = 8,
    parameter int unsigned INT_LIMIT = 32'h1000,
    localparam int         HW        = ADW - DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strap_int,
    input  logic [ADW-1:0] pc_in,
    input  logic           keep_second,
    input  logic [DW-1:0]  rom_data,
    input  logic           dm_req,
    input  logic           dm_write,
    input  logic           dm_wide,
    input  logic [ADW-1:0] dm_addr,
    input  logic [DW-1:0]  dm_wdata,
    input  logic [HW-1:0]  hi_latch,
    input  logic [DW-1:0]  lo_in,
    output logic [2:0]     state_idx,
    output logic           phase2,
    output logic           ale,
    output logic           psen_n,
    output logic           rd_n,
    output logic           wr_n,
    output logic [DW-1:0]  lo_out,
    output logic           lo_oe,
    output logic [HW-1:0]  hi_out,
    output logic           hi_oe,
    output logic [ADW-1:0] rom_addr,
    output logic           code_valid,
    output logic [DW-1:0]  code_byte,
    output logic           data_valid,
    output logic [DW-1:0]  data_byte,
    output logic           dm_active
);

    tick_e          tick;
    mode_e          mode;
    logic [ADW-1:0] fa;
    logic           fint;
    logic           r_wr;
    logic [DW-1:0]  r_alo;
    logic [HW-1:0]  r_hi;
    logic [DW-1:0]  r_wdata;

    mcb_tick_ring u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .state_idx (state_idx),
        .phase2    (phase2)
    );

    mcb_mode_fsm #(.ADW(ADW), .DW(DW)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .dm_req   (dm_req),
        .dm_write (dm_write),
        .dm_wide  (dm_wide),
        .dm_addr  (dm_addr),
        .dm_wdata (dm_wdata),
        .hi_latch (hi_latch),
        .mode     (mode),
        .r_wr     (r_wr),
        .r_alo    (r_alo),
        .r_hi     (r_hi),
        .r_wdata  (r_wdata)
    );

    mcb_fetch_capture #(.ADW(ADW), .DW(DW), .INT_LIMIT(INT_LIMIT)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .mode        (mode),
        .strap_int   (strap_int),
        .pc_in       (pc_in),
        .keep_second (keep_second),
        .rom_data    (rom_data),
        .lo_in       (lo_in),
        .r_wr        (r_wr),
        .fa          (fa),
        .fint        (fint),
        .code_valid  (code_valid),
        .code_byte   (code_byte),
        .data_valid  (data_valid),
        .data_byte   (data_byte)
    );

    mcb_strobe_gen #(.ADW(ADW), .DW(DW)) u_strb (
        .tick    (tick),
        .mode    (mode),
        .fa      (fa),
        .fint    (fint),
        .r_wr    (r_wr),
        .r_alo   (r_alo),
        .r_hi    (r_hi),
        .r_wdata (r_wdata),
        .ale     (ale),
        .psen_n  (psen_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .lo_out  (lo_out),
        .lo_oe   (lo_oe),
        .hi_out  (hi_out),
        .hi_oe   (hi_oe)
    );

    assign rom_addr  = fa;
    assign dm_active = (mode != M_FETCH);

endmodule

// File: rtl/mcb_bus_chk.sv
module mcb_bus_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] state_idx,
    input logic       phase2,
    input logic       ale,
    input logic       psen_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       lo_oe,
    input logic       code_valid,
    input logic       data_valid,
    input logic       dm_active
);

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !phase2 |=> phase2 && (state_idx == $past(state_idx)));  // R1

    AST_STATE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        phase2 |=> !phase2 &&
            (state_idx == (($past(state_idx) == 3'd5) ? 3'd0 : ($past(state_idx) + 3'd1))));  // R1

    AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> psen_n && rd_n && wr_n);  // R2

    AST_ALE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> phase2 && ((state_idx == 3'd0) || (state_idx == 3'd3)));  // R2

    AST_PSEN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> !lo_oe);  // R3

    AST_CODE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> !phase2 && ((state_idx == 3'd0) || (state_idx == 3'd3)));  // R6

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);  // R9

    AST_XFER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> dm_active);  // R9

    AST_RD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !lo_oe);  // R10

    AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> lo_oe);  // R10

    AST_DATA_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> dm_active && (state_idx == 3'd3) && !phase2);  // R10

endmodule

bind mcb_bus_seq mcb_bus_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_idx  (state_idx),
    .phase2     (phase2),
    .ale        (ale),
    .psen_n     (psen_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .lo_oe      (lo_oe),
    .code_valid (code_valid),
    .data_valid (data_valid),
    .dm_active  (dm_active)
);

// File: tb/sim_mcb_bus_seq.sv
`timescale 1ns/1ps
module sim_mcb_bus_seq;

    localparam int NCYC = 4000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        strap_int;
    logic [15:0] pc_in;
    logic        keep_second;
    logic [7:0]  rom_data;
    logic        dm_req, dm_write, dm_wide;
    logic [15:0] dm_addr;
    logic [7:0]  dm_wdata, hi_latch, lo_in;
    logic [2:0]  state_idx;
    logic        phase2, ale, psen_n, rd_n, wr_n, lo_oe, hi_oe;
    logic [7:0]  lo_out, hi_out, code_byte, data_byte;
    logic [15:0] rom_addr;
    logic        code_valid, data_valid, dm_active;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;  // 250 MHz

    function automatic logic [7:0] rom_fn(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign rom_data = rom_fn(rom_addr);

    mcb_bus_seq u0 (
        .clk(clk), .rst_n(rst_n), .strap_int(strap_int), .pc_in(pc_in),
        .keep_second(keep_second), .rom_data(rom_data), .dm_req(dm_req),
        .dm_write(dm_write), .dm_wide(dm_wide), .dm_addr(dm_addr),
        .dm_wdata(dm_wdata), .hi_latch(hi_latch), .lo_in(lo_in),
        .state_idx(state_idx), .phase2(phase2), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .lo_out(lo_out), .lo_oe(lo_oe),
        .hi_out(hi_out), .hi_oe(hi_oe), .rom_addr(rom_addr),
        .code_valid(code_valid), .code_byte(code_byte),
        .data_valid(data_valid), .data_byte(data_byte), .dm_active(dm_active)
    );

    // Behavioural model: tick number, cycle kind (0 fetch, 1 setup, 2 transfer).
    int          mt, mm;
    logic [15:0] mfa;
    bit          mfint, mwr, mcv, mdv;
    logic [7:0]  malo, mhi, mwd, mcb, mdb;

    task automatic model_reset();
        mt = 0; mm = 0; mfa = 0; mfint = 0; mwr = 0; mcv = 0; mdv = 0;
        malo = 0; mhi = 0; mwd = 0; mcb = 0; mdb = 0;
    endtask

    task automatic model_step();
        bit new_cv;
        bit new_dv;
        new_cv = 0;
        new_dv = 0;
        // R6 R7: code capture at end of S3P2 / S6P2
        if (mm == 0 && (mt == 5 || (mt == 11 && keep_second))) begin
            new_cv = 1;
            mcb = mfint ? rom_fn(mfa) : lo_in;
        end
        // R10: read data at end of S3P2 of transfer cycle
        if (mm == 2 && !mwr && mt == 5) begin
            new_dv = 1;
            mdb = lo_in;
        end
        // R8 R11: request sampled at end of S4P1 of a fetch cycle only
        if (mt == 6 && mm == 0 && dm_req) begin
            mm = 1; mwr = dm_write; malo = dm_addr[7:0]; mwd = dm_wdata;
            mhi = dm_wide ? dm_addr[15:8] : hi_latch;
        end else if (mt == 11 && mm == 1) begin
            mm = 2;
        end else if (mt == 11 && mm == 2) begin
            mm = 0;
        end
        // R4 R5: fetch address per slot
        if (mt == 0 || mt == 6) begin
            mfa = pc_in;
            mfint = strap_int && (pc_in < 16'h1000);
        end
        mcv = new_cv;
        mdv = new_dv;
        mt = (mt + 1) % 12;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h tick=%0d mode=%0d time=%0t", tag, act, exp, mt, mm, $time);
        end
    endtask

    task automatic compare(input bit in_rst);
        bit ina, inb, wina, winb, ext;
        logic [7:0] elo, ehi;
        bit eloe, ehoe, eale, epsen, erd, ewr;
        ina  = (mt == 1 || mt == 2);
        inb  = (mt == 7 || mt == 8);
        wina = (mt >= 1 && mt <= 5);
        winb = (mt >= 7);
        ext  = (mm == 0) && !mfint;
        eale = inb || (ina && mm != 2);
        epsen = !(ext && (mt == 4 || mt == 5 || mt == 10 || mt == 11));
        erd  = !(mm == 2 && !mwr && wina);
        ewr  = !(mm == 2 && mwr && wina);
        elo = 0; eloe = 0; ehi = 0; ehoe = 0;
        if (ext && (ina || inb)) begin eloe = 1; elo = mfa[7:0]; end
        else if (mm == 1 && inb) begin eloe = 1; elo = malo; end
        else if (mm == 2 && mwr && wina) begin eloe = 1; elo = mwd; end
        if (ext && (wina || winb)) begin ehoe = 1; ehi = mfa[15:8]; end
        else if (mm == 1 && winb) begin ehoe = 1; ehi = mhi; end
        else if (mm == 2 && mt <= 5) begin ehoe = 1; ehi = mhi; end
        if (in_rst) begin
            chk("R12 ale", 16'(ale), 16'(1'b0));
            chk("R12 psen_n", 16'(psen_n), 16'(1'b1));
            chk("R12 rd_n/wr_n", 16'({rd_n, wr_n}), 16'(2'b11));
            chk("R12 ports", 16'({lo_oe, hi_oe, lo_out, hi_out}), 16'(0));
            chk("R12 pulses", 16'({code_valid, data_valid, dm_active}), 16'(0));
            chk("R12 R1 tick", 16'({state_idx, phase2}), 16'(0));
        end else begin
            chk("R1 state", 16'(state_idx), 16'(mt / 2));
            chk("R1 phase", 16'(phase2), 16'(mt % 2));
            chk("R2 ale", 16'(ale), 16'(eale));
            chk("R3 R5 psen_n", 16'(psen_n), 16'(epsen));
            chk("R3 R8 R10 lo_oe", 16'(lo_oe), 16'(eloe));
            chk("R3 R8 R10 lo_out", 16'(lo_out), 16'(elo));
            chk("R3 R8 hi_oe", 16'(hi_oe), 16'(ehoe));
            chk("R3 R8 hi_out", 16'(hi_out), 16'(ehi));
            chk("R4 rom_addr", rom_addr, mfa);
            chk("R6 R7 code_valid", 16'(code_valid), 16'(mcv));
            chk("R5 R6 R7 code_byte", 16'(code_byte), 16'(mcb));
            chk("R9 rd_n", 16'(rd_n), 16'(erd));
            chk("R9 wr_n", 16'(wr_n), 16'(ewr));
            chk("R10 data_valid", 16'(data_valid), 16'(mdv));
            chk("R10 data_byte", 16'(data_byte), 16'(mdb));
            chk("R11 dm_active", 16'(dm_active), 16'(mm != 0));
        end
    endtask

    task automatic drive(input int c);
        int sel;
        sel = int'($urandom % 6);
        unique case (sel)
            0: pc_in = 16'h0FFF;
            1: pc_in = 16'h1000;
            2: pc_in = 16'h0FFE;
            3: pc_in = 16'h1001;
            4: pc_in = 16'($urandom) & 16'h0FFF;
            default: pc_in = 16'($urandom);
        endcase
        strap_int   = ((c / 400) % 3) != 2;
        keep_second = ($urandom % 4) != 0;
        dm_req      = (c >= 300) && (($urandom % 5) == 0);
        dm_write    = 1'($urandom);
        dm_wide     = 1'($urandom);
        dm_addr     = 16'($urandom);
        dm_wdata    = 8'($urandom);
        hi_latch    = 8'($urandom);
        lo_in       = 8'($urandom);
    endtask

    initial begin
        rst_n = 1'b0;
        drive(0);
        model_reset();
        repeat (4) begin
            @(negedge clk);
            compare(1'b1);
        end
        rst_n = 1'b1;
        drive(0);
        for (int c = 0; c < NCYC; c++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare(1'b0);
            drive(c);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule